// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block arbitrates the reset causes of a system-monitoring device. Four events can reset it: power-up, a software request to pulse the reset pin, a device-initialisation request, and an outside agent pulling the shared active-low reset pin. Each cause acts differently. It may clear the ordinary register set, clear the preserved locations (limit storage and fan-drive setting), and drive the reset pin low for a guaranteed minimum time. A separate request drives the chassis-intrusion line low for the same minimum time, so that an external intrusion latch is cleared.

The block holds the 8-bit configuration register, because three of its bits are self-clearing requests. All timing uses a one-cycle millisecond tick. The host writes the configuration register through a write strobe. The reset-enable mask bit arrives from the interrupt-mask logic. The pin level arrives already synchronised. The block does not drive any pad. It raises `pin_drive_low` and `intr_drive_low`, and the open-drain pad cells act on them. `regs_clear` and `keep_clear` are the strobes that the register file consumes.

Top module: `reset_hub`

## Requirements
- R1: While `rst_n` is low, `regs_clear` and `keep_clear` read 1, `cfg_q` reads 08h, `pin_drive_low` reads 1 and `intr_drive_low` reads 0. From the first clock edge after release, both clear strobes read 0. `keep_clear` is 1 only through power-on reset, and then only together with `regs_clear`.
- R2: The minimum hold has a fixed length. A pulse counts only the ticks sampled after the edge that started it. It releases its line at the edge that samples the 21st tick (PULSE_MS+1). Its line can drop only at an edge where a tick is sampled.
- R3: The host writes `cfg_q` bit 4 = 1 while `rst_out_en` = 1. Bit 4 then reads 1 for one cycle. At the next edge, `pin_drive_low` rises and bit 4 returns to 0. No clear strobe is issued.
- R4: The host writes bit 4 = 1 while `rst_out_en` = 0. The write stores 0 in bit 4 and the pin is not driven. The other written bits are stored unchanged.
- R5: The host writes bit 7 = 1. Bit 7 reads 1 for one cycle. At the next edge, `cfg_q` becomes 08h and `regs_clear` pulses for exactly one cycle. `keep_clear` stays 0 and `pin_drive_low` is not changed.
- R6: The host writes bit 6 = 1. At the next edge, `intr_drive_low` rises and bit 6 returns to 0. The line is released by the rule in R2.
- R7: The pin level is sampled low while the block is not driving the pin itself. Once 4 such ticks (DEBOUNCE_MS) have been sampled, the next edge accepts the reset. At the edge after that, `pin_drive_low` rises, `regs_clear` pulses for one cycle and `cfg_q` becomes 08h. `keep_clear` stays 0.
- R8: A low period on the pin that ends before its 4th tick causes no pin drive, no clear and no change to `cfg_q`. When the pin rises, the debounce count restarts from zero.
- R9: While the block drives the pin low itself, the low level is never taken as an external reset. No clear strobe occurs and the pulse ends on time.
- R10: A new start request that arrives during an active pulse restarts its tick count from zero.
- R11: A single write with bits 7, 6 and 4 set (and `rst_out_en` = 1) has three effects at the same edge. It issues one `regs_clear` pulse, drives both lines low, and returns `cfg_q` to 08h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ms_tick | input | 1 | One-cycle pulse once per millisecond |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| rst_out_en | input | 1 | Mask bit that permits the software reset pulse |
| pin_in_n | input | 1 | Synchronised level of the shared reset pin |
| cfg_q | output | 8 | Configuration register contents |
| pin_drive_low | output | 1 | Drive the reset pin low (open-drain enable) |
| intr_drive_low | output | 1 | Drive the chassis-intrusion line low |
| regs_clear | output | 1 | Clear strobe for the ordinary registers |
| keep_clear | output | 1 | Clear strobe for the preserved locations |

## Verification
The case of interest is one configuration write that both starts a software reset pulse and requests device initialisation. In the same edge, `cfg_q` must go to its default value while the self-clearing bit 4 still starts the pin timer. The bench provokes this with a single write that has bits 7, 6 and 4 set. It then expects three events at the same edge: one clear strobe, both lines driven, and `cfg_q` at 08h. Both lines are expected to release together on the 21st tick. The handover between external-reset acceptance and the block's own drive is also exercised, so that the pulse cannot re-trigger itself.

// File: rtl/reset_hub_pkg.sv
// Shared constants for the reset controller: register width, default
// value and the bit positions that the self-clearing requests use.
package reset_hub_pkg;
    localparam int CFG_W = 8;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h08;
    localparam int BIT_SWRST   = 4;
    localparam int BIT_CHS_CLR = 6;
    localparam int BIT_INIT    = 7;
    localparam int NUM_PULSE   = 2;
    localparam int PULSE_PIN   = 0;
    localparam int PULSE_CHS   = 1;
endpackage

// File: rtl/hub_pulse_timer.sv
// Minimum-width pulse generator. A start request raises the output and
// clears the count. The output drops on the tick that follows HOLD_TICKS
// counted ticks. Assumes that ms_tick is a one-cycle strobe.
module hub_pulse_timer #(
    parameter int   HOLD_TICKS   = 20,
    parameter logic START_ACTIVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic active
);
    localparam int CW = $clog2(HOLD_TICKS + 1);

    logic [CW-1:0] cnt;

    // Count ticks while active; a start request always restarts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= START_ACTIVE;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active && tick) begin
            if (cnt == CW'(HOLD_TICKS)) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/hub_pin_filter.sv
// Debounce for an external reset on the shared pin. The pin must be seen
// low on DEBOUNCE_TICKS ticks in a row before one accept strobe is issued.
// While the block drives the pin itself (mask), the count is held at zero.
// Assumes pin_low is already synchronised.
module hub_pin_filter #(
    parameter int DEBOUNCE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_low,
    input  logic mask,
    input  logic tick,
    output logic accept
);
    localparam int CW = $clog2(DEBOUNCE_TICKS + 1);

    logic [CW-1:0] cnt;
    logic          fired;

    // Count low ticks; fire once per low period and rearm when it ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            fired  <= 1'b0;
            accept <= 1'b0;
        end else begin
            accept <= 1'b0;
            if (!pin_low || mask) begin
                cnt   <= '0;
                fired <= 1'b0;
            end else if (tick && !fired) begin
                if (cnt == CW'(DEBOUNCE_TICKS - 1)) begin
                    accept <= 1'b1;
                    fired  <= 1'b1;
                    cnt    <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hub_cfg_reg.sv
// Configuration register with self-clearing request bits. A clear
// request restores the default value. The reset-request bit is dropped
// at write time when the enable mask is low. The request bits clear
// themselves once their action has started.
module hub_cfg_reg
    import reset_hub_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    input  logic             sw_en,
    input  logic             clear_all,
    input  logic             sw_fired,
    input  logic             chs_fired,
    output logic [CFG_W-1:0] q
);
    logic [CFG_W-1:0] wr_val;

    // Gate the software-reset request with its enable mask.
    always_comb begin
        wr_val            = wdata;
        wr_val[BIT_SWRST] = wdata[BIT_SWRST] & sw_en;
    end

    // Register update: clear first, then host write, then self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CFG_DEFAULT;
        end else if (clear_all) begin
            q <= CFG_DEFAULT;
        end else if (wr) begin
            q <= wr_val;
        end else begin
            if (sw_fired) begin
                q[BIT_SWRST] <= 1'b0;
            end
            if (chs_fired) begin
                q[BIT_CHS_CLR] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/reset_hub.sv
// Reset controller top. It combines power-on, software, initialisation and
// external pin resets into pin drive and clear strobes, and it drives the
// chassis line low on request. Assumes one ms_tick per millisecond and a
// synchronised pin_in_n.
module reset_hub
    import reset_hub_pkg::*;
#(
    parameter int PULSE_MS    = 20,
    parameter int DEBOUNCE_MS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rst_out_en,
    input  logic             pin_in_n,
    output logic [CFG_W-1:0] cfg_q,
    output logic             pin_drive_low,
    output logic             intr_drive_low,
    output logic             regs_clear,
    output logic             keep_clear
);
    logic                 sw_start;
    logic                 chs_start;
    logic                 init_req;
    logic                 hw_accept;
    logic                 clear_all;
    logic [NUM_PULSE-1:0] pulse_start;
    logic [NUM_PULSE-1:0] pulse_on;

    assign sw_start  = cfg_q[BIT_SWRST];
    assign chs_start = cfg_q[BIT_CHS_CLR];
    assign init_req  = cfg_q[BIT_INIT];
    assign clear_all = init_req | hw_accept;

    assign pulse_start[PULSE_PIN] = sw_start | hw_accept;
    assign pulse_start[PULSE_CHS] = chs_start;

    hub_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .wdata     (cfg_wdata),
        .sw_en     (rst_out_en),
        .clear_all (clear_all),
        .sw_fired  (sw_start),
        .chs_fired (chs_start),
        .q         (cfg_q)
    );

    hub_pin_filter #(.DEBOUNCE_TICKS(DEBOUNCE_MS)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_low (~pin_in_n),
        .mask    (pin_drive_low),
        .tick    (ms_tick),
        .accept  (hw_accept)
    );

    // One timer per driven line; only the reset pin is active from power-on.
    for (genvar gi = 0; gi < NUM_PULSE; gi++) begin : g_pulse
        hub_pulse_timer #(
            .HOLD_TICKS   (PULSE_MS),
            .START_ACTIVE ((gi == PULSE_PIN) ? 1'b1 : 1'b0)
        ) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .start  (pulse_start[gi]),
            .tick   (ms_tick),
            .active (pulse_on[gi])
        );
    end

    assign pin_drive_low  = pulse_on[PULSE_PIN];
    assign intr_drive_low = pulse_on[PULSE_CHS];

    // Clear strobes: both during power-on, ordinary set on init or pin reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_clear <= 1'b1;
            keep_clear <= 1'b1;
        end else begin
            regs_clear <= clear_all;
            keep_clear <= 1'b0;
        end
    end
endmodule

// File: rtl/reset_hub_chk.sv
// Property checker for reset_hub, attached through bind. It observes the
// ports only.
module reset_hub_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ms_tick,
    input logic       cfg_wr,
    input logic       rst_out_en,
    input logic [7:0] cfg_q,
    input logic       pin_drive_low,
    input logic       intr_drive_low,
    input logic       regs_clear,
    input logic       keep_clear
);
    a_r1_keep_only_at_por: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !keep_clear);

    a_r1_keep_with_regs: assert property (@(posedge clk) disable iff (!rst_n)
        keep_clear |-> regs_clear);

    a_r2_pin_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_drive_low) |-> $past(ms_tick));

    a_r2_chs_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_drive_low) |-> $past(ms_tick));

    a_r3_sw_pulse_starts: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[4] && !cfg_wr |=> pin_drive_low && !cfg_q[4]);

    a_r4_sw_gate: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && !rst_out_en |=> !cfg_q[4]);

    a_r5_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |=> regs_clear && (cfg_q == 8'h08));

    a_r6_chs_starts: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6] && !cfg_wr |=> intr_drive_low && !cfg_q[6]);
endmodule

bind reset_hub reset_hub_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ms_tick        (ms_tick),
    .cfg_wr         (cfg_wr),
    .rst_out_en     (rst_out_en),
    .cfg_q          (cfg_q),
    .pin_drive_low  (pin_drive_low),
    .intr_drive_low (intr_drive_low),
    .regs_clear     (regs_clear),
    .keep_clear     (keep_clear)
);

// File: tb/reset_hub_tb.sv
module reset_hub_tb;
    localparam int S_PIN  = 0;
    localparam int S_INTR = 1;
    localparam int S_RCLR = 2;
    localparam int S_KCLR = 3;
    localparam int S_CFG  = 4;

    typedef struct {
        int         at;
        int         sig;
        logic [7:0] val;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       rst_out_en = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin_in_n;
    logic [7:0] cfg_q;
    logic       pin_drive_low;
    logic       intr_drive_low;
    logic       regs_clear;
    logic       keep_clear;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    // Wired-AND model of the shared pin: external agent or own driver.
    assign pin_in_n = ~(ext_low | pin_drive_low);

    reset_hub u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .ms_tick        (ms_tick),
        .cfg_wr         (cfg_wr),
        .cfg_wdata      (cfg_wdata),
        .rst_out_en     (rst_out_en),
        .pin_in_n       (pin_in_n),
        .cfg_q          (cfg_q),
        .pin_drive_low  (pin_drive_low),
        .intr_drive_low (intr_drive_low),
        .regs_clear     (regs_clear),
        .keep_clear     (keep_clear)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] get_sig(input int s);
        case (s)
            S_PIN:   return {7'd0, pin_drive_low};
            S_INTR:  return {7'd0, intr_drive_low};
            S_RCLR:  return {7'd0, regs_clear};
            S_KCLR:  return {7'd0, keep_clear};
            default: return cfg_q;
        endcase
    endfunction

    // Scoreboard insertion, kept sorted by due cycle.
    task automatic expect_at(input int at, input int s, input logic [7:0] v, input string r);
        exp_t it;
        int   i;
        it.at = at; it.sig = s; it.val = v; it.req = r;
        i = 0;
        while (i < sb.size() && sb[i].at <= at) i++;
        sb.insert(i, it);
    endtask

    // Monitor: compares due items away from the active edge.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = get_sig(it.sig);
            checks++;
            if (it.at != cyc || act !== it.val) begin
                errors++;
                $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h", it.req, it.sig, it.at, act, it.val);
            end
        end
    end

    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1;
            @(negedge clk);
            ms_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        cfg_wr    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        while (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            errors++;
            $display("FAIL %s never compared: actual=none expected=%h", it.req, it.val);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int c;
        // R1: power-on state, then R2 release of the power-on pulse
        idle(3);
        c = cyc;
        expect_at(c + 1, S_RCLR, 8'h01, "R1");
        expect_at(c + 1, S_KCLR, 8'h01, "R1");
        expect_at(c + 1, S_PIN,  8'h01, "R1");
        expect_at(c + 1, S_INTR, 8'h00, "R1");
        expect_at(c + 1, S_CFG,  8'h08, "R1");
        expect_at(c + 2, S_RCLR, 8'h00, "R1");
        expect_at(c + 2, S_KCLR, 8'h00, "R1");
        expect_at(c + 42, S_PIN, 8'h01, "R2");
        expect_at(c + 43, S_PIN, 8'h00, "R2");
        idle(1);
        rst_n = 1'b1;
        idle(1);
        run_ticks(21);

        // R4: software reset request with the enable mask low is dropped
        rst_out_en = 1'b0;
        c = cyc;
        expect_at(c + 1, S_CFG, 8'h01, "R4");
        expect_at(c + 2, S_PIN, 8'h00, "R4");
        expect_at(c + 3, S_PIN, 8'h00, "R4");
        expect_at(c + 3, S_CFG, 8'h01, "R4");
        host_write(8'h11);
        idle(2);

        // R3 / R9 / R2: enabled software reset pulse
        rst_out_en = 1'b1;
        c = cyc;
        expect_at(c + 1, S_CFG,  8'h11, "R3");
        expect_at(c + 2, S_PIN,  8'h01, "R3");
        expect_at(c + 2, S_CFG,  8'h01, "R3");
        expect_at(c + 2, S_RCLR, 8'h00, "R3");
        expect_at(c + 10, S_RCLR, 8'h00, "R9");
        expect_at(c + 20, S_RCLR, 8'h00, "R9");
        expect_at(c + 20, S_CFG,  8'h01, "R9");
        expect_at(c + 42, S_PIN,  8'h01, "R2");
        expect_at(c + 43, S_PIN,  8'h00, "R2");
        expect_at(c + 46, S_PIN,  8'h00, "R9");
        host_write(8'h11);
        idle(1);
        run_ticks(21);
        idle(2);

        // R5: device initialisation
        c = cyc;
        expect_at(c + 1, S_CFG,  8'hA1, "R5");
        expect_at(c + 2, S_CFG,  8'h08, "R5");
        expect_at(c + 2, S_RCLR, 8'h01, "R5");
        expect_at(c + 2, S_KCLR, 8'h00, "R5");
        expect_at(c + 2, S_PIN,  8'h00, "R5");
        expect_at(c + 3, S_RCLR, 8'h00, "R5");
        host_write(8'hA1);
        idle(2);

        // R6 / R2: chassis line pulse
        c = cyc;
        expect_at(c + 1, S_CFG,  8'h41, "R6");
        expect_at(c + 2, S_INTR, 8'h01, "R6");
        expect_at(c + 2, S_CFG,  8'h01, "R6");
        expect_at(c + 2, S_PIN,  8'h00, "R6");
        expect_at(c + 42, S_INTR, 8'h01, "R2");
        expect_at(c + 43, S_INTR, 8'h00, "R2");
        host_write(8'h41);
        idle(1);
        run_ticks(21);

        // R10: restart of a running pulse
        c = cyc;
        expect_at(c + 23, S_CFG,  8'h41, "R10");
        expect_at(c + 64, S_INTR, 8'h01, "R10");
        expect_at(c + 65, S_INTR, 8'h00, "R10");
        host_write(8'h41);
        idle(1);
        run_ticks(10);
        host_write(8'h41);
        idle(1);
        run_ticks(21);

        // R8: short external lows are ignored and the count restarts
        c = cyc;
        expect_at(c + 7,  S_PIN,  8'h00, "R8");
        expect_at(c + 8,  S_RCLR, 8'h00, "R8");
        expect_at(c + 12, S_PIN,  8'h00, "R8");
        expect_at(c + 17, S_PIN,  8'h00, "R8");
        expect_at(c + 18, S_RCLR, 8'h00, "R8");
        expect_at(c + 18, S_CFG,  8'h01, "R8");
        ext_low = 1'b1;
        run_ticks(3);
        ext_low = 1'b0;
        run_ticks(2);
        ext_low = 1'b1;
        run_ticks(3);
        ext_low = 1'b0;
        idle(2);

        // R7 / R2: accepted external reset
        host_write(8'h03);
        idle(1);
        c = cyc;
        expect_at(c + 7, S_PIN,  8'h00, "R7");
        expect_at(c + 7, S_CFG,  8'h03, "R7");
        expect_at(c + 8, S_PIN,  8'h01, "R7");
        expect_at(c + 8, S_RCLR, 8'h01, "R7");
        expect_at(c + 8, S_CFG,  8'h08, "R7");
        expect_at(c + 8, S_KCLR, 8'h00, "R7");
        expect_at(c + 9, S_RCLR, 8'h00, "R7");
        expect_at(c + 48, S_PIN, 8'h01, "R2");
        expect_at(c + 49, S_PIN, 8'h00, "R2");
        ext_low = 1'b1;
        run_ticks(4);
        ext_low = 1'b0;
        run_ticks(21);

        // R11: initialisation, software reset and chassis clear in one write
        rst_out_en = 1'b1;
        c = cyc;
        expect_at(c + 1, S_CFG,  8'hD1, "R11");
        expect_at(c + 2, S_RCLR, 8'h01, "R11");
        expect_at(c + 2, S_PIN,  8'h01, "R11");
        expect_at(c + 2, S_INTR, 8'h01, "R11");
        expect_at(c + 2, S_CFG,  8'h08, "R11");
        expect_at(c + 3, S_RCLR, 8'h00, "R11");
        expect_at(c + 42, S_PIN,  8'h01, "R11");
        expect_at(c + 43, S_PIN,  8'h00, "R11");
        expect_at(c + 43, S_INTR, 8'h00, "R11");
        host_write(8'hD1);
        idle(1);
        run_ticks(21);
        idle(3);

        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL all-requirements watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule